// File: doc/BRIEF.md
# Multidrop Address Detect Filter

This block sits between a 9-bit serial receive engine and the receive FIFO of a multidrop bus node. For every completed received word it decides whether the word is written into the FIFO and whether the receive interrupt fires. In 9-bit operation the ninth bit marks the word type: 1 is an address word and 0 is a data word. While address detection is on, only address words reach the FIFO. Data words are dropped without leaving any trace, and every address word that passes raises the interrupt. The low byte of each forwarded address word is also presented on its own port, so host logic can compare it with the node address.

Once host logic has recognised its own address, it turns detection off. From then on every word passes, and the interrupt may be set to wait until the FIFO holds several words. At the end of the packet host logic turns detection back on. All outputs are registered: a word strobed in cycle N produces its effects in cycle N+1. Each control input is sampled in the same cycle as the word strobe, so a change to a control input only affects words that complete after the change.

Top module: `mdrop_addr_filter`

## Requirements
- R1: During and immediately after reset, fifo_wr, fifo_werr, rx_irq and addr_strobe are 0 and addr_byte is 0.
- R2: With nine_bit_mode=1 and addr_det_en=1, a word with rx_word[8]=0 causes no FIFO write, no interrupt and no address strobe.
- R3: With nine_bit_mode=1 and addr_det_en=1, a word with rx_word[8]=1 is written (fifo_wr=1, fifo_wdata = rx_word) one cycle after the strobe, and rx_irq pulses in that same cycle whatever irq_mode and fifo_level are.
- R4: With addr_det_en=0, every strobed word is written one cycle later, with fifo_wdata equal to rx_word in 9-bit mode.
- R5: When detection is not in force and irq_mode is 2'b00 or 2'b11, rx_irq pulses with every FIFO write.
- R6: When detection is not in force and irq_mode is 2'b01, rx_irq pulses with a write only when fifo_level in the strobe cycle is 2 (occupancy reaches 3).
- R7: When detection is not in force and irq_mode is 2'b10, rx_irq pulses with a write only when fifo_level in the strobe cycle is 3 (occupancy reaches the depth of 4).
- R8: With nine_bit_mode=0, addr_det_en has no effect. Every word is written with fifo_wdata[8]=0, irq_mode applies, and addr_strobe stays 0.
- R9: addr_strobe pulses with the write of each forwarded word that has nine_bit_mode=1 and rx_word[8]=1, and addr_byte then shows rx_word[7:0]. At all other times addr_byte holds its value.
- R10: addr_det_en is sampled in the strobe cycle. A change in the following cycle does not alter the handling of that word.
- R11: fifo_werr equals rx_ferr of the word being written. A dropped word leaves fifo_werr at 0, and no output pulses without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | One-cycle strobe for a completed received word |
| rx_word | input | 9 | Received word; bit 8 is the address marker in 9-bit mode |
| rx_ferr | input | 1 | Framing error flag of the received word |
| nine_bit_mode | input | 1 | 1 when the receiver is set for 9-bit words |
| addr_det_en | input | 1 | Address detection enable |
| irq_mode | input | 2 | 00/11 every word, 01 occupancy reaches 3, 10 FIFO full |
| fifo_level | input | 3 | FIFO occupancy before the current word |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 9 | Word written to the FIFO |
| fifo_werr | output | 1 | Framing error flag written alongside the word |
| rx_irq | output | 1 | Receive interrupt pulse |
| addr_strobe | output | 1 | Pulse marking a forwarded address word |
| addr_byte | output | 8 | Low byte of the last forwarded address word |

## Verification
The bench sweeps every combination of word width mode, detect enable, interrupt mode, FIFO level (0 to 4), address marker and error flag, with changing low-byte patterns. This separates dropped data words from passed address words, forced every-word interrupts from threshold interrupts, and the two threshold levels from each other. Directed sequences then toggle the enable in the cycle after a strobe, to show that the decision is taken at the strobe. They also follow a dropped word with idle cycles, to show that the address byte holds and that no spurious write or error flag appears.

// File: rtl/mdaf_pkg.sv
package mdaf_pkg;

   typedef enum logic [1:0] {
      IRQ_EACH = 2'b00,
      IRQ_MID  = 2'b01,
      IRQ_FULL = 2'b10,
      IRQ_ALT  = 2'b11
   } irq_mode_e;

   typedef struct packed {
      logic pass;
      logic is_addr;
      logic det_on;
   } gate_t;

endpackage

// File: rtl/mdaf_gate.sv
module mdaf_gate (
   input  logic              valid,
   input  logic              marker,
   input  logic              nine_bit,
   input  logic              det_en,
   output mdaf_pkg::gate_t   dec
);
   logic det_on;
   logic is_addr;

   always_comb begin
      det_on      = nine_bit & det_en;
      is_addr     = nine_bit & marker;
      dec.det_on  = det_on;
      dec.is_addr = is_addr;
      dec.pass    = valid & (~det_on | is_addr);
   end
endmodule

// File: rtl/mdaf_irq_sel.sv
module mdaf_irq_sel #(
   parameter int DEPTH  = 4,
   parameter int MID    = 3,
   parameter int LVL_W  = 3
) (
   input  mdaf_pkg::gate_t    dec,
   input  logic [1:0]         mode,
   input  logic [LVL_W-1:0]   level,
   output logic               irq
);
   import mdaf_pkg::*;

   localparam logic [LVL_W-1:0] MID_PRE  = LVL_W'(MID - 1);
   localparam logic [LVL_W-1:0] FULL_PRE = LVL_W'(DEPTH - 1);

   irq_mode_e eff_mode;
   logic      hit_mid;
   logic      hit_full;

   always_comb begin
      eff_mode = dec.det_on ? IRQ_EACH : irq_mode_e'(mode);
      hit_mid  = (level == MID_PRE);
      hit_full = (level == FULL_PRE);
      unique case (eff_mode)
         IRQ_MID:  irq = dec.pass & hit_mid;
         IRQ_FULL: irq = dec.pass & hit_full;
         default:  irq = dec.pass;
      endcase
   end
endmodule

// File: rtl/mdaf_out_reg.sv
module mdaf_out_reg #(
   parameter int DATA_W     = 8,
   parameter bit CLEAR_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  mdaf_pkg::gate_t   dec,
   input  logic              irq_in,
   input  logic [DATA_W:0]   word_in,
   input  logic              err_in,
   output logic              wr,
   output logic [DATA_W:0]   wdata,
   output logic              werr,
   output logic              irq,
   output logic              astrobe,
   output logic [DATA_W-1:0] abyte
);
   logic addr_take;

   always_comb addr_take = dec.pass & dec.is_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr      <= 1'b0;
         werr    <= 1'b0;
         irq     <= 1'b0;
         astrobe <= 1'b0;
         abyte   <= '0;
      end else begin
         wr      <= dec.pass;
         werr    <= dec.pass & err_in;
         irq     <= irq_in;
         astrobe <= addr_take;
         if (addr_take) abyte <= word_in[DATA_W-1:0];
      end
   end

   generate
      if (CLEAR_DATA) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        wdata <= '0;
            else if (dec.pass) wdata <= word_in;
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (dec.pass) wdata <= word_in;
         end
      end
   endgenerate
endmodule

// File: rtl/mdrop_addr_filter.sv
module mdrop_addr_filter #(
   parameter int DATA_W     = 8,
   parameter int DEPTH      = 4,
   parameter int MID        = 3,
   parameter bit CLEAR_DATA = 1'b1,
   parameter int LVL_W      = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [DATA_W:0]   rx_word,
   input  logic              rx_ferr,
   input  logic              nine_bit_mode,
   input  logic              addr_det_en,
   input  logic [1:0]        irq_mode,
   input  logic [LVL_W-1:0]  fifo_level,
   output logic              fifo_wr,
   output logic [DATA_W:0]   fifo_wdata,
   output logic              fifo_werr,
   output logic              rx_irq,
   output logic              addr_strobe,
   output logic [DATA_W-1:0] addr_byte
);
   import mdaf_pkg::*;

   initial begin
      if (DATA_W < 1)               $error("DATA_W must be at least 1");
      if (MID < 1 || MID >= DEPTH)  $error("MID must lie in 1..DEPTH-1");
      if ((1 << LVL_W) <= DEPTH)    $error("LVL_W too narrow for DEPTH");
   end

   gate_t             dec;
   logic              irq_next;
   logic [DATA_W:0]   word_fmt;

   always_comb begin
      word_fmt         = rx_word;
      word_fmt[DATA_W] = nine_bit_mode & rx_word[DATA_W];
   end

   mdaf_gate i_gate (
      .valid    (rx_valid),
      .marker   (rx_word[DATA_W]),
      .nine_bit (nine_bit_mode),
      .det_en   (addr_det_en),
      .dec      (dec)
   );

   mdaf_irq_sel #(.DEPTH(DEPTH), .MID(MID), .LVL_W(LVL_W)) i_irq (
      .dec   (dec),
      .mode  (irq_mode),
      .level (fifo_level),
      .irq   (irq_next)
   );

   mdaf_out_reg #(.DATA_W(DATA_W), .CLEAR_DATA(CLEAR_DATA)) i_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .dec     (dec),
      .irq_in  (irq_next),
      .word_in (word_fmt),
      .err_in  (rx_ferr),
      .wr      (fifo_wr),
      .wdata   (fifo_wdata),
      .werr    (fifo_werr),
      .irq     (rx_irq),
      .astrobe (addr_strobe),
      .abyte   (addr_byte)
   );
endmodule

// File: rtl/mdaf_checker.sv
module mdaf_checker #(
   parameter int DATA_W = 8,
   parameter int LVL_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_valid,
   input logic [DATA_W:0]   rx_word,
   input logic              nine_bit_mode,
   input logic              addr_det_en,
   input logic [1:0]        irq_mode,
   input logic [LVL_W-1:0]  fifo_level,
   input logic              fifo_wr,
   input logic [DATA_W:0]   fifo_wdata,
   input logic              rx_irq,
   input logic              addr_strobe,
   input logic [DATA_W-1:0] addr_byte
);
   assert_drop_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && nine_bit_mode && addr_det_en && !rx_word[DATA_W]) |=> !fifo_wr);

   assert_addr_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && nine_bit_mode && addr_det_en && rx_word[DATA_W]) |=> (fifo_wr && rx_irq));

   assert_pass_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !(nine_bit_mode && addr_det_en)) |=> fifo_wr);

   assert_irq_with_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> fifo_wr);

   assert_mid_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !(nine_bit_mode && addr_det_en) && irq_mode == 2'b01 && fifo_level != LVL_W'(2))
      |=> !rx_irq);

   assert_eight_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !nine_bit_mode) |=> (!addr_strobe && !fifo_wdata[DATA_W]));

   assert_strobe_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      addr_strobe |-> (fifo_wr && fifo_wdata[DATA_W] && addr_byte == fifo_wdata[DATA_W-1:0]));

   assert_byte_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_strobe |-> $stable(addr_byte));

   assert_no_spurious_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |=> (!fifo_wr && !rx_irq && !addr_strobe));
endmodule

bind mdrop_addr_filter mdaf_checker #(.DATA_W(DATA_W), .LVL_W(LVL_W)) i_mdaf_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .rx_valid      (rx_valid),
   .rx_word       (rx_word),
   .nine_bit_mode (nine_bit_mode),
   .addr_det_en   (addr_det_en),
   .irq_mode      (irq_mode),
   .fifo_level    (fifo_level),
   .fifo_wr       (fifo_wr),
   .fifo_wdata    (fifo_wdata),
   .rx_irq        (rx_irq),
   .addr_strobe   (addr_strobe),
   .addr_byte     (addr_byte)
);

// File: tb/test_mdrop_addr_filter.sv
module test_mdrop_addr_filter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_valid = 1'b0;
   logic [8:0] rx_word = '0;
   logic       rx_ferr = 1'b0;
   logic       nine_bit_mode = 1'b0;
   logic       addr_det_en = 1'b0;
   logic [1:0] irq_mode = 2'b00;
   logic [2:0] fifo_level = '0;
   logic       fifo_wr;
   logic [8:0] fifo_wdata;
   logic       fifo_werr;
   logic       rx_irq;
   logic       addr_strobe;
   logic [7:0] addr_byte;

   int checks = 0;
   int fails  = 0;
   logic [7:0] exp_byte = '0;

   always #4 clk = ~clk;

   mdrop_addr_filter i_mdrop_addr_filter (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_word(rx_word),
      .rx_ferr(rx_ferr), .nine_bit_mode(nine_bit_mode), .addr_det_en(addr_det_en),
      .irq_mode(irq_mode), .fifo_level(fifo_level), .fifo_wr(fifo_wr),
      .fifo_wdata(fifo_wdata), .fifo_werr(fifo_werr), .rx_irq(rx_irq),
      .addr_strobe(addr_strobe), .addr_byte(addr_byte)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle_check(input string tag);
      rx_valid = 1'b0;
      @(negedge clk);
      chk({tag, " idle wr/irq/strobe/err"}, {12'd0, fifo_wr, rx_irq, addr_strobe, fifo_werr}, 16'd0);
      chk({tag, " addr_byte hold"}, {8'd0, addr_byte}, {8'd0, exp_byte});
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset outputs", {7'd0, fifo_wr, fifo_werr, rx_irq, addr_strobe, addr_byte},
          16'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset", {7'd0, fifo_wr, fifo_werr, rx_irq, addr_strobe, addr_byte}, 16'd0);

      // sweep
      for (int idx = 0; idx < 640; idx++) begin
         logic nb, en, mk, fe, det, isad, pass, irq_e;
         logic [1:0] md, eff;
         logic [2:0] lv;
         logic [7:0] lo;
         string tag;
         nb = idx[0]; en = idx[1]; md = idx[3:2]; mk = idx[4]; fe = idx[5];
         lv = 3'((idx >> 6) % 5);
         lo = 8'((idx * 37 + 5) & 255);
         @(negedge clk);
         nine_bit_mode = nb; addr_det_en = en; irq_mode = md; fifo_level = lv;
         rx_word = {mk, lo}; rx_ferr = fe; rx_valid = 1'b1;
         det  = nb & en;
         isad = nb & mk;
         pass = ~det | isad;
         eff  = det ? 2'b00 : md;
         irq_e = pass & ((eff == 2'b01) ? (lv == 3'd2) : (eff == 2'b10) ? (lv == 3'd3) : 1'b1);
         if (!nb)            tag = "R8";
         else if (det && !mk) tag = "R2";
         else if (det)       tag = "R3";
         else                tag = "R4";
         @(negedge clk);
         rx_valid = 1'b0;
         if (pass && isad) exp_byte = lo;
         chk({tag, " fifo_wr"}, {15'd0, fifo_wr}, {15'd0, pass});
         if (pass) chk({tag, " fifo_wdata"}, {7'd0, fifo_wdata}, {7'd0, nb & mk, lo});
         chk((eff == 2'b01) ? "R6 irq" : (eff == 2'b10) ? "R7 irq" : "R5 irq",
             {15'd0, rx_irq}, {15'd0, irq_e});
         chk("R9 addr_strobe", {15'd0, addr_strobe}, {15'd0, pass & isad});
         chk("R9 addr_byte", {8'd0, addr_byte}, {8'd0, exp_byte});
         chk("R11 fifo_werr", {15'd0, fifo_werr}, {15'd0, pass & fe});
      end

      // R10: enable flips in cycle after strobe
      @(negedge clk);
      nine_bit_mode = 1'b1; addr_det_en = 1'b0; irq_mode = 2'b10; fifo_level = 3'd0;
      rx_word = 9'h05A; rx_ferr = 1'b0; rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0; addr_det_en = 1'b1;
      chk("R10 data word written despite later enable", {15'd0, fifo_wr}, 16'd1);
      chk("R10 wdata", {7'd0, fifo_wdata}, 16'h005A);
      rx_word = 9'h033; rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0; addr_det_en = 1'b0;
      chk("R10 next data word dropped", {15'd0, fifo_wr}, 16'd0);
      idle_check("R11");

      // R2/R11: dropped word with error flag, then hold
      @(negedge clk);
      addr_det_en = 1'b1; rx_word = 9'h0C3; rx_ferr = 1'b1; rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0;
      chk("R2 dropped no write/irq", {14'd0, fifo_wr, rx_irq}, 16'd0);
      chk("R11 dropped no error", {15'd0, fifo_werr}, 16'd0);
      chk("R9 addr_byte kept after drop", {8'd0, addr_byte}, {8'd0, exp_byte});
      idle_check("R9");

      // R3: address forced every-word irq at full mode, level 0
      @(negedge clk);
      irq_mode = 2'b10; fifo_level = 3'd0; rx_word = 9'h1A7; rx_ferr = 1'b0; rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0; exp_byte = 8'hA7;
      chk("R3 addr write+irq", {14'd0, fifo_wr, rx_irq}, 16'd3);
      chk("R9 addr_byte", {8'd0, addr_byte}, 16'h00A7);
      idle_check("R11");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule